// File: doc/BRIEF.md
# Two-Dimensional Product Code Encoder

The block turns a serial stream of information bits into a square product-code array. Bits arrive one per handshake and fill a k-by-k array in row-major order, with a start flag on the first bit of each block. As each information row completes it is extended into a codeword of an extended Hamming component code: the cyclic check bits come from dividing by the generator polynomial, and one overall even-parity bit follows. The same component code is then applied down every one of the n columns, so the bottom rows hold column checks and the final row holds column parity. The lower-right corner holds checks computed over checks. Every row and every column of the n-by-n result is a component codeword. The minimum distance of the array is the square of the component distance, and its rate is the square of the component rate.

With the default parameters the component code is the extended (32,26) code, with generator x^5+x^2+1. The input side and the output side are both valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. The input is ready only while a block is being filled. From the edge that accepts the last information bit until the last coded bit is taken, the input is held off with `in_ready` low. The output presents one bit per beat in row-major order, and it holds its data whenever the consumer stalls. Only one array is stored, so filling and draining never overlap.

Top module: `prod_code_enc`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A bit is accepted on a rising edge where `in_valid` and `in_ready` are both 1. A bit accepted with `in_first`=1 becomes row 0, column 0. The following accepted bits fill the k-by-k information array row by row, with the column index advancing fastest.
- R3: A bit accepted with `in_first`=0 while no block is open is discarded and has no effect on any later output. No block is open after reset, or after the last output bit of a block has been taken.
- R4: A bit accepted with `in_first`=1 in the middle of filling abandons the partial block and starts a new one with that bit at row 0, column 0.
- R5: In every output row, positions 0..k-1 carry that row's information bits in order. Positions k..n-2 carry the remainder of u(x)·x^M mod g(x), highest coefficient first, where position t has degree n-2-t. Position n-1 makes the whole row's parity even. With the defaults g(x)=x^5+x^2+1, M=5, n=32, k=26.
- R6: Every output column, read from row 0 down to row n-1, is a codeword of the same component code. Rows k..n-2 are the column check bits and row n-1 is the column parity.
- R7: The output delivers exactly n·n bits per block in row-major order. `out_last` is 1 on the final bit only.
- R8: `in_ready` is 0 from the edge that accepts the k·k-th information bit until the edge that takes the last output bit. `out_valid` first rises M+1 clock edges after the accepting edge. After the last output bit is taken, `out_valid` is 0 and `in_ready` is 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Encoder accepts an information bit |
| in_data | input | 1 | Information bit value |
| in_first | input | 1 | Offered bit is the first bit of a block |
| out_valid | output | 1 | Coded bit offered |
| out_ready | input | 1 | Consumer takes the coded bit |
| out_data | output | 1 | Coded bit value |
| out_last | output | 1 | Offered bit is the final bit of the array |

## Verification
The assertions check the stream protocol on every cycle. They cover the exclusion between filling and draining, holding under stall, the position of `out_last`, and the return to an idle, ready state after the last beat. Whether the coded bits are correct cannot be seen from any single cycle. The bench's scenarios check the algebra: they compare each array with one computed by polynomial long division, and check the syndrome and parity of every row and column. They also cover the discarding of stray bits, restart on a mid-block start flag, and the fill-to-drain latency. These scenarios run on a small configuration over an all-zero block, an all-one block, every single-bit block and many pseudo-random blocks, with random stalls on both sides.

// File: rtl/prod_code_pkg.sv
package prod_code_pkg;

  // Sequencer phases of the encoder
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,  // accepting information bits, rows encoded on the fly
    ST_FLUSH = 2'd1,  // writing column check rows and the parity row
    ST_SEND  = 2'd2   // streaming the coded array out
  } pc_state_e;

endpackage

// File: rtl/pc_row_enc.sv
// Combinational systematic encoder for one component codeword.
// Position t of the info vector is transmitted at position t.
module pc_row_enc #(
  parameter int            M    = 5,
  parameter logic [M-1:0]  POLY = 5'b00101,
  parameter int            N    = 1 << M,
  parameter int            K    = N - 1 - M
) (
  input  logic [K-1:0] info,
  output logic [N-1:0] cw
);

  logic [M-1:0] st [K+1];
  logic [K-1:0] fb;

  assign st[0] = '0;

  // Unrolled Galois division, one stage per information bit
  for (genvar t = 0; t < K; t++) begin : g_div
    assign fb[t]    = info[t] ^ st[t][M-1];
    assign st[t+1]  = {st[t][M-2:0], 1'b0} ^ ({M{fb[t]}} & POLY);
  end

  assign cw[K-1:0] = info;

  for (genvar j = 0; j < M; j++) begin : g_chk
    assign cw[K+j] = st[K][M-1-j];
  end

  assign cw[N-1] = (^info) ^ (^st[K]);

endmodule

// File: rtl/pc_col_lfsr.sv
// Serial divider for one column; steps once per completed row, then
// shifts its remainder out most significant bit first.
module pc_col_lfsr #(
  parameter int            M    = 5,
  parameter logic [M-1:0]  POLY = 5'b00101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic din,
  input  logic shift,
  output logic msb
);

  logic [M-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (clr) begin
      rem_q <= '0;
    end else if (step) begin
      rem_q <= {rem_q[M-2:0], 1'b0} ^ ({M{din ^ rem_q[M-1]}} & POLY);
    end else if (shift) begin
      rem_q <= {rem_q[M-2:0], 1'b0};
    end
  end

  assign msb = rem_q[M-1];

endmodule

// File: rtl/pc_array.sv
// n-by-n bit array: whole-row write, single-bit read.
module pc_array #(
  parameter int N  = 32,
  parameter int RW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [N-1:0]  wdata,
  input  logic [RW-1:0] raddr,
  input  logic [RW-1:0] rcol,
  output logic          rbit
);

  logic [N-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rbit = mem[raddr][rcol];

endmodule

// File: rtl/prod_code_enc.sv
module prod_code_enc
  import prod_code_pkg::*;
#(
  parameter int            M    = 5,
  parameter logic [M-1:0]  POLY = 5'b00101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_data,
  input  logic in_first,
  output logic out_valid,
  input  logic out_ready,
  output logic out_data,
  output logic out_last
);

  localparam int N  = 1 << M;
  localparam int K  = N - 1 - M;
  localparam int RW = $clog2(N);
  localparam int JW = $clog2(M + 1);

  pc_state_e     state;
  logic          active;
  logic [RW-1:0] r_cnt, c_cnt;
  logic [RW-1:0] o_row, o_col;
  logic [JW-1:0] j_cnt;
  logic [K-1:0]  row_buf, row_now;
  logic [N-1:0]  cw_row, chk_row, par_acc, wdata;
  logic [RW-1:0] waddr;
  logic          we;
  logic          accept, start, take, row_done, blk_done;
  logic          flushing, flush_par;

  assign in_ready  = (state == ST_FILL);
  assign out_valid = (state == ST_SEND);
  assign out_last  = out_valid && (o_row == RW'(N-1)) && (o_col == RW'(N-1));

  assign accept    = in_valid && in_ready;
  assign start     = accept && in_first;
  assign take      = accept && active && !in_first;
  assign row_done  = take && (c_cnt == RW'(K-1));
  assign blk_done  = row_done && (r_cnt == RW'(K-1));
  assign flushing  = (state == ST_FLUSH);
  assign flush_par = flushing && (j_cnt == JW'(M));

  // Current row with the arriving bit merged in
  always_comb begin
    row_now        = row_buf;
    row_now[c_cnt] = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_buf <= '0;
    end else if (start) begin
      row_buf <= {{(K-1){1'b0}}, in_data};
    end else if (take) begin
      row_buf[c_cnt] <= in_data;
    end
  end

  pc_row_enc #(.M(M), .POLY(POLY), .N(N), .K(K)) u_row_enc (
    .info (row_now),
    .cw   (cw_row)
  );

  // One column divider per array column
  for (genvar c = 0; c < N; c++) begin : g_col
    pc_col_lfsr #(.M(M), .POLY(POLY)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .step  (row_done),
      .din   (cw_row[c]),
      .shift (flushing),
      .msb   (chk_row[c])
    );
  end

  // Running XOR of every row written so far gives the parity row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_acc <= '0;
    end else if (start) begin
      par_acc <= '0;
    end else if (row_done) begin
      par_acc <= par_acc ^ cw_row;
    end else if (flushing && !flush_par) begin
      par_acc <= par_acc ^ chk_row;
    end
  end

  assign we    = row_done || flushing;
  assign waddr = row_done ? r_cnt : (RW'(K) + RW'(j_cnt));
  assign wdata = row_done ? cw_row : (flush_par ? par_acc : chk_row);

  pc_array #(.N(N), .RW(RW)) u_array (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (o_row),
    .rcol  (o_col),
    .rbit  (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_FILL;
      active <= 1'b0;
      r_cnt  <= '0;
      c_cnt  <= '0;
      j_cnt  <= '0;
      o_row  <= '0;
      o_col  <= '0;
    end else begin
      case (state)
        ST_FILL: begin
          if (start) begin
            active <= 1'b1;
            r_cnt  <= '0;
            c_cnt  <= RW'(1);
          end else if (take) begin
            if (row_done) begin
              c_cnt <= '0;
              if (blk_done) begin
                state  <= ST_FLUSH;
                active <= 1'b0;
                j_cnt  <= '0;
              end else begin
                r_cnt <= r_cnt + RW'(1);
              end
            end else begin
              c_cnt <= c_cnt + RW'(1);
            end
          end
        end
        ST_FLUSH: begin
          if (flush_par) begin
            state <= ST_SEND;
            o_row <= '0;
            o_col <= '0;
          end else begin
            j_cnt <= j_cnt + JW'(1);
          end
        end
        ST_SEND: begin
          if (out_ready) begin
            if (out_last) begin
              state <= ST_FILL;
            end else if (o_col == RW'(N-1)) begin
              o_col <= '0;
              o_row <= o_row + RW'(1);
            end else begin
              o_col <= o_col + RW'(1);
            end
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

endmodule

// File: rtl/prod_code_enc_chk.sv
module prod_code_enc_chk #(
  parameter int NN = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_data,
  input logic out_last
);

  localparam int CW = $clog2(NN) + 1;

  logic [CW-1:0] beat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
    end else if (out_valid && out_ready) begin
      beat_cnt <= out_last ? '0 : beat_cnt + CW'(1);
    end
  end

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_last_position_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (beat_cnt == CW'(NN-1))));

  assert_idle_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  assert_no_input_when_draining_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && out_last)) |=> !in_ready);

  // in_valid is observed for completeness of the stream interface
  logic unused_in_valid;
  assign unused_in_valid = in_valid;

endmodule

bind prod_code_enc prod_code_enc_chk #(.NN((1 << M) * (1 << M))) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/prod_code_enc_test.sv
module prod_code_enc_test;

  localparam int M  = 3;
  localparam logic [M-1:0] POLY = 3'b011;   // g(x) = x^3 + x + 1
  localparam int N  = 1 << M;
  localparam int K  = N - 1 - M;
  localparam int NN = N * N;
  localparam int KK = K * K;
  localparam logic [M:0] GFULL = {1'b1, POLY};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_data = 1'b0, in_first = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_data, out_last;

  always #10 clk = ~clk;

  prod_code_enc #(.M(M), .POLY(POLY)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_first(in_first),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] rs = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd_next(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Polynomial remainder by long division; bit index = degree
  function automatic logic [M-1:0] poly_rem(input logic [N-2:0] v);
    logic [N-2:0] w = v;
    for (int d = N - 2; d >= M; d--) begin
      if (w[d]) w = w ^ ((N-1)'(GFULL) << (d - M));
    end
    return w[M-1:0];
  endfunction

  function automatic logic [N-1:0] ref_enc(input logic [K-1:0] u);
    logic [N-2:0] v = '0;
    logic [M-1:0] r;
    logic [N-1:0] cw = '0;
    for (int t = 0; t < K; t++) begin
      v[N-2-t] = u[t];
      cw[t]    = u[t];
    end
    r = poly_rem(v);
    for (int j = 0; j < M; j++) cw[K+j] = r[M-1-j];
    cw[N-1] = ^cw[N-2:0];
    return cw;
  endfunction

  function automatic bit is_codeword(input logic [N-1:0] cw);
    logic [N-2:0] v;
    for (int t = 0; t < N - 1; t++) v[N-2-t] = cw[t];
    return (poly_rem(v) == '0) && ((^cw) == 1'b0);
  endfunction

  // Flattened array, index r*N + c
  function automatic logic [NN-1:0] ref_array(input logic [KK-1:0] info);
    logic [NN-1:0] a = '0;
    logic [N-1:0] rw, cl;
    logic [K-1:0] u;
    for (int r = 0; r < K; r++) begin
      rw = ref_enc(info[r*K +: K]);
      for (int c = 0; c < N; c++) a[r*N+c] = rw[c];
    end
    for (int c = 0; c < N; c++) begin
      for (int r = 0; r < K; r++) u[r] = a[r*N+c];
      cl = ref_enc(u);
      for (int r = K; r < N; r++) a[r*N+c] = cl[r];
    end
    return a;
  endfunction

  task automatic put_beat(input logic d, input logic f);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_first = f;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic junk_beats(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      rs = rnd_next(rs);
      put_beat(rs[0], 1'b0);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_block(input logic [KK-1:0] info);
    int cnt;
    for (int i = 0; i < KK; i++) begin
      rs = rnd_next(rs);
      if (rs[3:0] == 4'd0) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      put_beat(info[i], i == 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    cnt = 0;
    while (!out_valid && cnt < 40) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    check(cnt == M + 1, "R8 fill-to-drain latency", cnt, M + 1);
  endtask

  task automatic get_block(input logic [KK-1:0] info, input bit stall);
    logic [NN-1:0] got = '0;
    logic [NN-1:0] exp_a;
    logic [N-1:0] vec;
    int idx = 0, ready_bad = 0, hold_bad = 0, last_bad = 0, row_bad = 0, col_bad = 0, guard = 0;
    bit have_prev = 0;
    logic pd = 1'b0, pl = 1'b0;
    exp_a = ref_array(info);
    while (idx < NN && guard < 4 * NN) begin
      guard++;
      rs = rnd_next(rs);
      out_ready = stall ? rs[1] : 1'b1;
      if (in_ready) ready_bad++;
      if (have_prev && !(out_valid && out_data == pd && out_last == pl)) hold_bad++;
      have_prev = 0;
      if (out_valid) begin
        if (out_ready) begin
          got[idx] = out_data;
          if (out_last != (idx == NN - 1)) last_bad++;
          idx++;
        end else begin
          have_prev = 1;
          pd = out_data;
          pl = out_last;
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(idx == NN, "R7 beat count", idx, NN);
    check(got == exp_a, "R2 array contents", got, exp_a);
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) vec[c] = got[r*N+c];
      if (!is_codeword(vec)) row_bad++;
    end
    check(row_bad == 0, "R5 row syndrome/parity", row_bad, 0);
    for (int c = 0; c < N; c++) begin
      for (int r = 0; r < N; r++) vec[r] = got[r*N+c];
      if (!is_codeword(vec)) col_bad++;
    end
    check(col_bad == 0, "R6 column syndrome/parity", col_bad, 0);
    check(ready_bad == 0, "R8 in_ready low while draining", ready_bad, 0);
    check(hold_bad == 0, "R9 hold under stall", hold_bad, 0);
    check(last_bad == 0, "R7 out_last position", last_bad, 0);
    check(!out_valid && in_ready, "R8 idle after last", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic run_block(input logic [KK-1:0] info, input bit stall);
    send_block(info);
    get_block(info, stall);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [KK-1:0] info;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready, "R1 reset state", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);

    // R3: stray bits before any start flag
    junk_beats(5);
    run_block('0, 1'b0);
    run_block('1, 1'b1);

    // Every single-bit block
    for (int b = 0; b < KK; b++) begin
      info = '0;
      info[b] = 1'b1;
      if (b % 3 == 0) junk_beats(3);   // R3: stray bits between blocks
      run_block(info, b[0]);
    end

    // R4: partial blocks abandoned by a new start flag
    for (int p = 1; p < KK; p += 4) begin
      for (int i = 0; i < p; i++) begin
        rs = rnd_next(rs);
        put_beat(1'b1 ^ rs[2], i == 0);
      end
      rs = rnd_next(rs);
      info = rs[KK-1:0];
      run_block(info, 1'b1);
    end

    // Pseudo-random blocks
    for (int n = 0; n < 40; n++) begin
      rs = rnd_next(rs);
      info = rs[KK-1:0];
      if (n % 5 == 0) junk_beats(2);
      run_block(info, n[0]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule